// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block gathers single-cycle completion and error pulses from a bank of DMA channels and turns them into one interrupt line. Each channel can raise four kinds of event: the whole descriptor chain finished, one descriptor node finished, and two separate error kinds. Every event kind has its own latched raw register, an enable mask and a masked view. A summary register shows, per channel, whether any enabled event is waiting, and the interrupt output is high whenever that summary is non-zero.

Software services the line by reading the summary and masked views, then writes ones into the raw registers to acknowledge the events it has handled. The channel engine can also flush every pending event of one channel with a kill pulse when that channel is aborted. A read-only register shows which channels the engine reports as busy. The register port is a plain address, write strobe and write data, with read data decoded combinationally from the address.

Top module: `dmairq_aggr`

## Requirements
- R1: After reset all raw registers and all masks read 0, the summary reads 0 and `irq` is low.
- R2: A pulse on an event input for channel c sets bit c of that class's raw register at the next clock edge. The bit stays set until it is cleared. The classes are index 0 chain done, 1 node done, 2 error A and 3 error B. Raw class k reads at byte offset 0x30+4k.
- R3: The masked register of class k, at offset 0x10+4k, reads raw AND mask. A mask bit of 1 enables that channel. Mask class k lives at offset 0x20+4k.
- R4: The summary register at offset 0x00 has bit c set exactly when any class has bit c set in its masked view.
- R5: `irq` is the OR of all summary bits. It is low before the edge that captures an enabled event and high just after that edge.
- R6: Writing to a raw register clears each bit whose write data bit is 1. Bits written 0 are left unchanged.
- R7: If an event and a clear hit the same raw bit in the same cycle, the bit ends up set.
- R8: A pulse on `ch_kill[c]` clears bit c in all four raw registers and leaves every other channel alone.
- R9: The busy register at offset 0x40 reads `ch_busy`, zero-extended to the data width.
- R10: Mask writes store only the low NUM_CH bits of the write data, and reads return those bits zero-extended.
- R11: Writes to the summary, masked-view and busy offsets change no raw or mask state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, decoded combinationally from bus_addr |
| ev_chain_done | input | NUM_CH | Per-channel pulse: chain complete (class 0) |
| ev_node_done | input | NUM_CH | Per-channel pulse: node complete (class 1) |
| ev_err_a | input | NUM_CH | Per-channel pulse: error kind A (class 2) |
| ev_err_b | input | NUM_CH | Per-channel pulse: error kind B (class 3) |
| ch_kill | input | NUM_CH | Per-channel pulse: flush all raw events of that channel |
| ch_busy | input | NUM_CH | Per-channel busy level from the engine |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong raw bit shows up at once in three places: the raw read-back, the masked view and the summary. It also shows on `irq` in the same cycle, so a lost or stuck event is visible right after the edge that should have changed it. Mask errors show as a masked view that differs from raw AND mask with no delay. The clear-versus-event race and the kill path each get a targeted cycle, so a wrong priority leaves a bit at the wrong value on the very next read.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   localparam int NCLS = 4;

   typedef enum logic [1:0] {
      CLS_CHAIN = 2'd0,
      CLS_NODE  = 2'd1,
      CLS_ERRA  = 2'd2,
      CLS_ERRB  = 2'd3
   } evcls_e;

   localparam int OFS_SUMMARY   = 'h00;
   localparam int OFS_PEND_BASE = 'h10;
   localparam int OFS_MASK_BASE = 'h20;
   localparam int OFS_RAW_BASE  = 'h30;
   localparam int OFS_BUSY      = 'h40;
   localparam int OFS_STRIDE    = 4;
endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
   import dmairq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                          bus_wr,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [NUM_CH-1:0]             wbits,
   input  logic [NUM_CH-1:0]             ch_kill,
   output logic [NCLS-1:0]               mask_we,
   output logic [NCLS-1:0][NUM_CH-1:0]   clr_vec
);
   for (genvar k = 0; k < NCLS; k++) begin : g_cls
      localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(OFS_MASK_BASE + OFS_STRIDE*k);
      localparam logic [ADDR_W-1:0] RAW_A  = ADDR_W'(OFS_RAW_BASE + OFS_STRIDE*k);
      logic raw_hit;
      assign raw_hit    = bus_wr && (bus_addr == RAW_A);
      assign mask_we[k] = bus_wr && (bus_addr == MASK_A);
      assign clr_vec[k] = (raw_hit ? wbits : '0) | ch_kill;
   end
endmodule

// File: rtl/dmairq_latch.sv
module dmairq_latch #(
   parameter int NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_in,
   input  logic [NUM_CH-1:0] clr_in,
   output logic [NUM_CH-1:0] raw_q
);
   // set dominates clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= set_in | (raw_q & ~clr_in);
   end
endmodule

// File: rtl/dmairq_mask.sv
module dmairq_mask #(
   parameter int NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [NUM_CH-1:0] wbits,
   output logic [NUM_CH-1:0] mask_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  mask_q <= '0;
      else if (we) mask_q <= wbits;
   end
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
   import dmairq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [NCLS-1:0][NUM_CH-1:0] raw_q,
   input  logic [NCLS-1:0][NUM_CH-1:0] mask_q,
   input  logic [NCLS-1:0][NUM_CH-1:0] pend,
   input  logic [NUM_CH-1:0]           summary,
   input  logic [NUM_CH-1:0]           ch_busy,
   output logic [DATA_W-1:0]           bus_rdata
);
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_SUMMARY)) bus_rdata = DATA_W'(summary);
      if (bus_addr == ADDR_W'(OFS_BUSY))    bus_rdata = DATA_W'(ch_busy);
      for (int k = 0; k < NCLS; k++) begin
         if (bus_addr == ADDR_W'(OFS_PEND_BASE + OFS_STRIDE*k)) bus_rdata = DATA_W'(pend[k]);
         if (bus_addr == ADDR_W'(OFS_MASK_BASE + OFS_STRIDE*k)) bus_rdata = DATA_W'(mask_q[k]);
         if (bus_addr == ADDR_W'(OFS_RAW_BASE + OFS_STRIDE*k))  bus_rdata = DATA_W'(raw_q[k]);
      end
   end
endmodule

// File: rtl/dmairq_aggr.sv
module dmairq_aggr
   import dmairq_pkg::*;
#(
   parameter int NUM_CH    = 16,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter bit IRQ_FLOP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ev_chain_done,
   input  logic [NUM_CH-1:0] ev_node_done,
   input  logic [NUM_CH-1:0] ev_err_a,
   input  logic [NUM_CH-1:0] ev_err_b,
   input  logic [NUM_CH-1:0] ch_kill,
   input  logic [NUM_CH-1:0] ch_busy,
   output logic              irq
);
   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("dmairq_aggr: NUM_CH must lie in 1..DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("dmairq_aggr: ADDR_W too small for the register map");
   end

   logic [NUM_CH-1:0]           wbits;
   logic [NCLS-1:0][NUM_CH-1:0] ev_all;
   logic [NCLS-1:0][NUM_CH-1:0] clr_vec;
   logic [NCLS-1:0][NUM_CH-1:0] raw_q;
   logic [NCLS-1:0][NUM_CH-1:0] mask_q;
   logic [NCLS-1:0][NUM_CH-1:0] pend;
   logic [NCLS-1:0]             mask_we;
   logic [NUM_CH-1:0]           summary;

   assign wbits = bus_wdata[NUM_CH-1:0];
   if (NUM_CH < DATA_W) begin : g_hi
      logic wdata_unused;
      assign wdata_unused = ^bus_wdata[DATA_W-1:NUM_CH];
   end

   assign ev_all[CLS_CHAIN] = ev_chain_done;
   assign ev_all[CLS_NODE]  = ev_node_done;
   assign ev_all[CLS_ERRA]  = ev_err_a;
   assign ev_all[CLS_ERRB]  = ev_err_b;

   dmairq_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .wbits   (wbits),
      .ch_kill (ch_kill),
      .mask_we (mask_we),
      .clr_vec (clr_vec)
   );

   for (genvar k = 0; k < NCLS; k++) begin : g_cls
      dmairq_latch #(.NUM_CH(NUM_CH)) u_raw (
         .clk   (clk),
         .rst_n (rst_n),
         .set_in(ev_all[k]),
         .clr_in(clr_vec[k]),
         .raw_q (raw_q[k])
      );
      dmairq_mask #(.NUM_CH(NUM_CH)) u_mask (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (mask_we[k]),
         .wbits (wbits),
         .mask_q(mask_q[k])
      );
      assign pend[k] = raw_q[k] & mask_q[k];
   end

   always_comb begin
      summary = '0;
      for (int k = 0; k < NCLS; k++) summary |= pend[k];
   end

   if (IRQ_FLOP) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |summary;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |summary;
   end

   dmairq_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .bus_addr (bus_addr),
      .raw_q    (raw_q),
      .mask_q   (mask_q),
      .pend     (pend),
      .summary  (summary),
      .ch_busy  (ch_busy),
      .bus_rdata(bus_rdata)
   );
endmodule

// File: rtl/dmairq_aggr_chk.sv
module dmairq_aggr_chk
   import dmairq_pkg::*;
#(
   parameter int NUM_CH   = 16,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit IRQ_FLOP = 1'b0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [DATA_W-1:0]             bus_wdata,
   input logic [DATA_W-1:0]             bus_rdata,
   input logic [NCLS-1:0][NUM_CH-1:0]   ev_all,
   input logic [NUM_CH-1:0]             ch_kill,
   input logic [NUM_CH-1:0]             ch_busy,
   input logic [NCLS-1:0][NUM_CH-1:0]   raw_q,
   input logic [NCLS-1:0][NUM_CH-1:0]   mask_q,
   input logic                          irq
);
   logic [NUM_CH-1:0] any_pend;
   logic              chk_unused;
   assign chk_unused = ^bus_wdata;

   always_comb begin
      any_pend = '0;
      for (int k = 0; k < NCLS; k++) any_pend |= raw_q[k] & mask_q[k];
   end

   for (genvar k = 0; k < NCLS; k++) begin : g_cls
      logic [NUM_CH-1:0] clr_exp;
      assign clr_exp = ((bus_wr && bus_addr == ADDR_W'(OFS_RAW_BASE + OFS_STRIDE*k))
                        ? bus_wdata[NUM_CH-1:0] : '0) | ch_kill;

      // R2
      raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> ((raw_q[k] & $past(ev_all[k])) == $past(ev_all[k])));

      // R6
      raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> ((raw_q[k] & $past(clr_exp & ~ev_all[k])) == '0));

      // R7
      raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> ((raw_q[k] & ~$past(raw_q[k]) & ~$past(ev_all[k])) == '0));

      // R3
      pend_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == ADDR_W'(OFS_PEND_BASE + OFS_STRIDE*k))
            |-> (bus_rdata == DATA_W'(raw_q[k] & mask_q[k])));
   end

   if (!IRQ_FLOP) begin : g_irq
      // R5
      irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq == (|any_pend));
   end

   // R9
   busy_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_BUSY)) |-> (bus_rdata == DATA_W'(ch_busy)));

   // R4
   summary_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_SUMMARY)) |-> (bus_rdata == DATA_W'(any_pend)));
endmodule

bind dmairq_aggr dmairq_aggr_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_FLOP(IRQ_FLOP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .ev_all   (ev_all),
   .ch_kill  (ch_kill),
   .ch_busy  (ch_busy),
   .raw_q    (raw_q),
   .mask_q   (mask_q),
   .irq      (irq)
);

// File: tb/sim_dmairq_aggr.sv
`timescale 1ns/1ps
module sim_dmairq_aggr;
   localparam int N  = 16;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [N-1:0]  ev [4];
   logic [N-1:0]  ch_kill = '0;
   logic [N-1:0]  ch_busy = '0;
   logic          irq;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   dmairq_aggr #(.NUM_CH(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_chain_done(ev[0]), .ev_node_done(ev[1]), .ev_err_a(ev[2]), .ev_err_b(ev[3]),
      .ch_kill(ch_kill), .ch_busy(ch_busy), .irq(irq)
   );

   // {class, event pattern, mask, expected masked view}
   localparam logic [49:0] TBL [7] = '{
      {2'd0, 16'h0001, 16'hFFFF, 16'h0001},
      {2'd1, 16'h8000, 16'h8000, 16'h8000},
      {2'd2, 16'h00F0, 16'h0030, 16'h0030},
      {2'd3, 16'hAAAA, 16'h5555, 16'h0000},
      {2'd0, 16'hFFFF, 16'h0000, 16'h0000},
      {2'd1, 16'h1234, 16'h0F0F, 16'h0204},
      {2'd3, 16'hC3C3, 16'hFF00, 16'hC300}
   };

   function automatic logic [AW-1:0] a_pend(int k); return AW'('h10 + 4*k); endfunction
   function automatic logic [AW-1:0] a_mask(int k); return AW'('h20 + 4*k); endfunction
   function automatic logic [AW-1:0] a_raw(int k);  return AW'('h30 + 4*k); endfunction

   task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic pulse(int k, logic [N-1:0] p);
      @(negedge clk);
      ev[k] = p;
      @(posedge clk); #1 ev[k] = '0;
   endtask

   task automatic clear_raw();
      for (int k = 0; k < 4; k++) wr(a_raw(k), '1);
   endtask

   initial begin
      #(8*100000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      for (int k = 0; k < 4; k++) ev[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd('h00, d); chk("R1 summary", d, 0);
      rd(a_raw(2), d); chk("R1 raw", d, 0);
      rd(a_mask(1), d); chk("R1 mask", d, 0);
      chk("R1 irq", DW'(irq), 0);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < 7; i++) begin
         int cls;
         logic [15:0] evp, msk, exp;
         cls = int'(TBL[i][49:48]); evp = TBL[i][47:32];
         msk = TBL[i][31:16];      exp = TBL[i][15:0];
         clear_raw();
         wr(a_mask(cls), DW'(msk));
         pulse(cls, evp);
         rd(a_raw(cls), d);  chk("R2 raw latch", d, DW'(evp));
         rd(a_pend(cls), d); chk("R3 masked view", d, DW'(exp));
         rd('h00, d);        chk("R4 summary", d, DW'(exp));
         chk("R5 irq level", DW'(irq), DW'(exp != 0));
         wr(a_mask(cls), 0);
      end

      // R4 several classes merge
      clear_raw();
      for (int k = 0; k < 4; k++) wr(a_mask(k), '1);
      pulse(0, 16'h0002);
      pulse(3, 16'h0200);
      rd('h00, d); chk("R4 merged summary", d, 32'h0202);

      // R5 edge timing
      clear_raw();
      @(negedge clk);
      ev[2] = 16'h0010;
      #1 chk("R5 irq before edge", DW'(irq), 0);
      @(posedge clk); #1 ev[2] = '0;
      chk("R5 irq after edge", DW'(irq), 1);

      // R6 partial clear
      clear_raw();
      pulse(2, 16'h000F);
      wr(a_raw(2), 32'h0000_0005);
      rd(a_raw(2), d); chk("R6 w1c", d, 32'h0000_000A);

      // R7 event vs clear same cycle
      clear_raw();
      pulse(0, 16'h0008);
      @(negedge clk);
      bus_addr = a_raw(0); bus_wdata = 32'h0000_0018; bus_wr = 1'b1;
      ev[0] = 16'h0018;
      @(posedge clk); #1 bus_wr = 1'b0; ev[0] = '0;
      rd(a_raw(0), d); chk("R7 set wins", d, 32'h0000_0018);

      // R8 kill
      clear_raw();
      for (int k = 0; k < 4; k++) pulse(k, 16'h0060);
      @(negedge clk) ch_kill = 16'h0020;
      @(posedge clk); #1 ch_kill = '0;
      for (int k = 0; k < 4; k++) begin
         rd(a_raw(k), d); chk("R8 kill", d, 32'h0000_0040);
      end

      // R9 busy
      ch_busy = 16'hA5A5;
      rd('h40, d); chk("R9 busy", d, 32'h0000_A5A5);

      // R10 mask width
      wr(a_mask(3), 32'hFFFF_FFFF);
      rd(a_mask(3), d); chk("R10 mask stored", d, 32'h0000_FFFF);

      // R11 writes to read-only views ignored
      wr('h00, 0); wr(a_pend(1), 0); wr('h40, '1);
      rd(a_raw(1), d);  chk("R11 raw kept", d, 32'h0000_0040);
      rd(a_mask(3), d); chk("R11 mask kept", d, 32'h0000_FFFF);

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule